// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block paces the serial clock of an I2C master and tells the byte shifter beside it when to change and when to read the data line. Software packs five fields into one 32-bit timing word. A 4-bit divider turns the kernel clock into a time quantum, and the SCL low time, the SCL high time, the data hold delay after SCL falls and the data setup margin before SCL rises are all counted in that quantum.

The generator drives SCL low with an open-drain pull and watches the real line through a synchroniser. A phase starts counting only once the line is seen at its new level. A target that holds SCL low, or a slow rising edge, therefore makes the high phase longer instead of shortening it. The timing word is taken in while the block is disabled and stays frozen while it runs. Clearing the enable releases the line and silences both strobes in the same cycle.

Top module: `i2c_scl_timer`

## Requirements
- R1: During reset and whenever `enable` is low, `scl_pull_o`, `data_upd_o` and `data_smp_o` are all low.
- R2: The timing word is laid out as follows: bits 31:28 hold the divider D, bits 23:20 the setup field S, bits 19:16 the hold field H, bits 15:8 the high count C and bits 7:0 the low count L. Bits 27:24 are ignored. One quantum is Q = D+1 kernel clocks. When (L+1)·Q is at least H·Q+1+(S+1)·Q, each SCL low phase (`scl_pull_o` high) lasts SYNC_STAGES+1+(L+1)·Q clocks.
- R3: Without clock stretching, each SCL high phase (`scl_pull_o` low between two low phases) lasts SYNC_STAGES+1+(C+1)·Q clocks.
- R4: `data_upd_o` pulses for exactly one clock in every low phase, SYNC_STAGES+H·Q+1 clocks after the first clock of `scl_pull_o`.
- R5: SCL is released no earlier than (S+1)·Q clocks after the update strobe. A low phase therefore lasts SYNC_STAGES+1+max((L+1)·Q, H·Q+1+(S+1)·Q) clocks.
- R6: `data_smp_o` pulses for exactly one clock in every high phase: the first clock of the high count, after the synchronised line has been seen high.
- R7: If the line is held low externally for K clocks after release, the sample strobe and the whole high phase are delayed by K clocks.
- R8: The timing word is captured in every clock while disabled, including the first clock in which `enable` is seen high. Changes to `timing_cfg` while enabled have no effect on any phase length or strobe position.
- R9: Dropping `enable` suppresses a strobe due in that same clock and releases SCL at once. After at least SYNC_STAGES+1 disabled clocks, re-enabling starts a fresh low phase that follows R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset, already released synchronously |
| enable | input | 1 | Peripheral enable; low releases SCL and holds all counters |
| timing_cfg | input | 32 | Packed timing word (layout in R2) |
| scl_line_i | input | 1 | Observed SCL line level |
| scl_pull_o | output | 1 | 1 = pull SCL low, 0 = release |
| data_upd_o | output | 1 | One-clock strobe: shifter may change SDA now |
| data_smp_o | output | 1 | One-clock strobe: shifter samples SDA now |

## Verification
Two events can fall in the same clock. The first is a disable request arriving in the very clock in which the update strobe is due. The bench locates the first pulled clock, counts forward to the predicted strobe clock, confirms the strobe is present, then lowers `enable` mid-cycle and checks that the strobe and the SCL pull both vanish before the next edge. The second is a new timing word written in the same clock that `enable` rises. The scoreboard expects the new word's phase lengths and ignores a later write made while running.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;

  // Phase of the SCL generator
  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_LWAIT = 3'd1,  // pulling low, waiting to see the line low
    PH_LCNT  = 3'd2,  // counting the low phase
    PH_HWAIT = 3'd3,  // released, waiting to see the line high
    PH_HCNT  = 3'd4   // counting the high phase
  } phase_e;

  // Used fields of the timing word (reserved nibble removed)
  typedef struct packed {
    logic [3:0] quant;
    logic [3:0] setup;
    logic [3:0] hold;
    logic [7:0] hi;
    logic [7:0] lo;
  } tfields_t;

endpackage

// File: rtl/i2c_tgen_cfg.sv
module i2c_tgen_cfg
  import i2c_tgen_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [31:0]      cfg_i,
  output logic [CNT_W-1:0] low_eff_o,
  output logic [CNT_W-1:0] high_n_o,
  output logic [CNT_W-1:0] hold_n_o
);

  tfields_t fld_d, fld_q;
  logic     rsv_unused;

  assign rsv_unused = ^cfg_i[27:24];

  always_comb begin
    fld_d = fld_q;
    if (capture) fld_d = tfields_t'({cfg_i[31:28], cfg_i[23:0]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fld_q <= '0;
    else        fld_q <= fld_d;
  end

  logic [CNT_W-1:0] q_w, low_n, setup_n, need_n;

  always_comb begin
    q_w       = CNT_W'(fld_q.quant) + CNT_W'(1);
    low_n     = (CNT_W'(fld_q.lo) + CNT_W'(1)) * q_w;
    high_n_o  = (CNT_W'(fld_q.hi) + CNT_W'(1)) * q_w;
    hold_n_o  = CNT_W'(fld_q.hold) * q_w + CNT_W'(1);
    setup_n   = (CNT_W'(fld_q.setup) + CNT_W'(1)) * q_w;
    need_n    = hold_n_o + setup_n;
    low_eff_o = (low_n > need_n) ? low_n : need_n;
  end

endmodule

// File: rtl/i2c_tgen_sync.sv
module i2c_tgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  localparam int SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] sh_d, sh_q;

  always_comb sh_d = {sh_q[SW-2:0], line_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;   // idle bus reads high
    else        sh_q <= sh_d;
  end

  assign line_o = sh_q[SW-1];

endmodule

// File: rtl/i2c_tgen_cnt.sv
module i2c_tgen_cnt #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_tgen_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [31:0] timing_cfg,
  input  logic        scl_line_i,
  output logic        scl_pull_o,
  output logic        data_upd_o,
  output logic        data_smp_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           phase_d, phase_q;
  logic             line_s;
  logic [CNT_W-1:0] cnt, low_eff, high_n, hold_n;
  logic             cnt_clr, cnt_inc, capture;

  assign capture = (phase_q == PH_OFF);

  i2c_tgen_cfg #(.CNT_W(CNT_W)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .cfg_i    (timing_cfg),
    .low_eff_o(low_eff),
    .high_n_o (high_n),
    .hold_n_o (hold_n)
  );

  i2c_tgen_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .line_i(scl_line_i),
    .line_o(line_s)
  );

  i2c_tgen_cnt #(.W(CNT_W)) cnt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .cnt_o(cnt)
  );

  // Next phase
  always_comb begin
    phase_d = phase_q;
    if (!enable) begin
      phase_d = PH_OFF;
    end else begin
      unique case (phase_q)
        PH_OFF:   phase_d = PH_LWAIT;
        PH_LWAIT: if (!line_s) phase_d = PH_LCNT;
        PH_LCNT:  if (cnt == low_eff - ONE) phase_d = PH_HWAIT;
        PH_HWAIT: if (line_s) phase_d = PH_HCNT;
        PH_HCNT:  if (cnt == high_n - ONE) phase_d = PH_LWAIT;
        default:  phase_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_OFF;
    else        phase_q <= phase_d;
  end

  assign cnt_clr = (phase_d != phase_q);
  assign cnt_inc = (phase_q == PH_LCNT) || (phase_q == PH_HCNT);

  // Outputs, qualified by enable in the same cycle
  assign scl_pull_o = enable && ((phase_q == PH_LWAIT) || (phase_q == PH_LCNT));
  assign data_upd_o = enable && (phase_q == PH_LCNT) && (cnt == hold_n - ONE);
  assign data_smp_o = enable && (phase_q == PH_HCNT) && (cnt == '0);

endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_line_i,
  input logic scl_pull_o,
  input logic data_upd_o,
  input logic data_smp_o
);

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!scl_pull_o && !data_upd_o && !data_smp_o));

  assert_upd_in_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_upd_o |-> scl_pull_o);

  assert_upd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_upd_o |=> !data_upd_o);

  assert_setup_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_upd_o |=> (scl_pull_o || !enable));

  assert_smp_line_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_smp_o |-> (!scl_pull_o && scl_line_i));

  assert_stretch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull_o && !scl_line_i) |-> !data_smp_o);

  assert_restart_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$past(enable, 2)) |-> scl_pull_o);

endmodule

bind i2c_scl_timer i2c_scl_timer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .scl_line_i(scl_line_i),
  .scl_pull_o(scl_pull_o),
  .data_upd_o(data_upd_o),
  .data_smp_o(data_smp_o)
);

// File: tb/i2c_scl_timer_tb_top.sv
module i2c_scl_timer_tb_top;

  localparam int SYNC = 2;

  logic        clk;
  logic        rst_n;
  logic        enable;
  logic [31:0] timing_cfg;
  logic        scl_line;
  logic        scl_pull, data_upd, data_smp;
  logic        tgt_hold;

  assign scl_line = !(scl_pull || tgt_hold);

  i2c_scl_timer #(.CNT_W(14), .SYNC_STAGES(SYNC)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .timing_cfg(timing_cfg),
    .scl_line_i(scl_line),
    .scl_pull_o(scl_pull),
    .data_upd_o(data_upd),
    .data_smp_o(data_smp)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    bit    hi;
    int    len;
    int    off;
    string tl;
    string to;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   stretch_req = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // ---------------- monitor ----------------
  bit prev_pull;
  bit armed;
  int run, upd_at, smp_at, hold_left;

  initial begin
    tgt_hold = 1'b0;
    prev_pull = 0; armed = 0; run = 0; upd_at = -1; smp_at = -1; hold_left = 0;
  end

  always @(negedge clk) begin
    if (!rst_n || !enable) begin
      armed = 0; prev_pull = 0; run = 0; upd_at = -1; smp_at = -1;
      hold_left = 0; tgt_hold = 1'b0;
    end else begin
      if (hold_left > 0) begin
        hold_left--;
        if (hold_left == 0) tgt_hold = 1'b0;
      end
      if (scl_pull != prev_pull) begin
        if (armed && q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          check(e.hi == !prev_pull, e.tl, "phase kind", int'(!prev_pull), int'(e.hi));
          check(run == e.len, e.tl, e.hi ? "high length" : "low length", run, e.len);
          check((e.hi ? smp_at : upd_at) == e.off, e.to,
                e.hi ? "sample offset" : "update offset",
                e.hi ? smp_at : upd_at, e.off);
        end
        if (!prev_pull) armed = 1;
        run = 0; upd_at = -1; smp_at = -1;
        if (!scl_pull && stretch_req > 0) begin
          tgt_hold  = 1'b1;
          hold_left = stretch_req;
        end
      end
      if (data_upd) upd_at = run;
      if (data_smp) smp_at = run;
      run++;
      prev_pull = scl_pull;
    end
  end

  // ---------------- driver ----------------
  task automatic calc(input logic [31:0] c, input int stretch,
                      output int lo_len, output int lo_off,
                      output int hi_len, output int hi_off, output bit setup_dom);
    int qn, low_n, high_n, hold_n, setup_n, eff;
    qn      = int'(c[31:28]) + 1;
    low_n   = (int'(c[7:0]) + 1) * qn;
    high_n  = (int'(c[15:8]) + 1) * qn;
    hold_n  = int'(c[19:16]) * qn + 1;
    setup_n = (int'(c[23:20]) + 1) * qn;
    setup_dom = (hold_n + setup_n) > low_n;
    eff     = setup_dom ? hold_n + setup_n : low_n;
    lo_len  = SYNC + 1 + eff;
    lo_off  = SYNC + hold_n;
    hi_len  = SYNC + 1 + stretch + high_n;
    hi_off  = SYNC + 1 + stretch;
  endtask

  // pre: word written while disabled; cfg: written with the enable edge;
  // mid: written while running (must be ignored)
  task automatic run_cfg(input logic [31:0] pre, input logic [31:0] cfg,
                         input logic [31:0] mid, input int pairs,
                         input int stretch, input string tag);
    int lo_len, lo_off, hi_len, hi_off;
    bit sdom;
    exp_t e;
    calc(cfg, stretch, lo_len, lo_off, hi_len, hi_off, sdom);
    stretch_req = stretch;
    for (int i = 0; i < pairs; i++) begin
      e.hi = 0; e.len = lo_len; e.off = lo_off; e.to = "R4";
      e.tl = (tag != "") ? tag : (sdom ? "R5" : "R2");
      q.push_back(e);
      e.hi = 1; e.len = hi_len; e.off = hi_off; e.to = (stretch > 0) ? "R7" : "R6";
      e.tl = (tag != "") ? tag : ((stretch > 0) ? "R7" : "R3");
      q.push_back(e);
    end
    tick(); timing_cfg = pre;
    repeat (2) tick();
    timing_cfg = cfg; enable = 1'b1;
    while (q.size() > 2 * pairs - 2) tick();
    timing_cfg = mid;
    while (q.size() > 0) tick();
    repeat (2) tick();
    enable = 1'b0;
    repeat (8) tick();
    stretch_req = 0;
  endtask

  localparam logic [31:0] CFG_A   = {4'd0, 4'd0, 4'd1, 4'd2, 8'd3, 8'd4};
  localparam logic [31:0] CFG_B   = {4'd2, 4'd0, 4'd3, 4'd5, 8'd1, 8'd3};
  localparam logic [31:0] CFG_C   = {4'd1, 4'hF, 4'd0, 4'd0, 8'd7, 8'd9};
  localparam logic [31:0] CFG_MIN = 32'h0;
  localparam logic [31:0] CFG_MAX = {4'd15, 4'd0, 4'd15, 4'd15, 8'd0, 8'd255};

  initial begin
    rst_n = 1'b0; enable = 1'b0; timing_cfg = '0;
    repeat (2) @(posedge clk);
    #3;
    check(!scl_pull && !data_upd && !data_smp, "R1", "outputs in reset",
          int'({scl_pull, data_upd, data_smp}), 0);
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) tick();
    check(!scl_pull && !data_upd && !data_smp, "R1", "outputs disabled",
          int'({scl_pull, data_upd, data_smp}), 0);

    run_cfg(CFG_A, CFG_A, CFG_A, 3, 0, "");       // R2 R3 R4 R6
    run_cfg(CFG_B, CFG_B, CFG_B, 3, 0, "");       // R5: setup extends low
    run_cfg(CFG_C, CFG_C, CFG_C, 3, 5, "");       // R7: stretch of 5
    run_cfg(CFG_A, CFG_B, CFG_C, 4, 0, "R8");     // R8: word at enable edge, later write ignored
    run_cfg(CFG_MIN, CFG_MIN, CFG_MIN, 2, 0, ""); // smallest counts
    run_cfg(CFG_MAX, CFG_MAX, CFG_MAX, 1, 0, ""); // largest low count

    // R9: drop enable in the very cycle the update strobe is due (CFG_A: offset 5)
    tick(); timing_cfg = CFG_A;
    repeat (2) tick();
    enable = 1'b1;
    do begin @(posedge clk); #1; end while (!scl_pull);
    repeat (SYNC + 3) @(posedge clk);
    #1;
    check(data_upd == 1'b1, "R4", "strobe due before disable", int'(data_upd), 1);
    #1 enable = 1'b0;
    #1;
    check(!data_upd && !scl_pull, "R9", "same-cycle suppression",
          int'({data_upd, scl_pull}), 0);
    begin
      int seen = 0;
      for (int i = 0; i < 30; i++) begin
        tick();
        #1;
        if (scl_pull || data_upd || data_smp) seen++;
      end
      check(seen == 0, "R1", "busy cycles while disabled", seen, 0);
    end
    run_cfg(CFG_A, CFG_A, CFG_A, 2, 0, "R9");     // fresh restart

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog: actual %0d cycles expected completion", 200000);
    finish_run();
  end

endmodule